// File: doc/BRIEF.md
# Forwarding Table Store with Indirect Register Access

This block holds a table of 68-bit forwarding entries and gives software a small register port to reach them. Software never addresses an entry directly. It writes up to three 32-bit staging words, then writes a table-control register with a command bit and an index. A clear command in bit 31 loads the addressed entry into the staging words. A set bit 31 commits the staging words into the entry at that index.

The staging words are ordered against bit significance. The word at the lowest offset holds the most significant bits of the entry, and the word at the highest offset holds bits 31:0. A status register reports the table size as a 5-bit code in units of 1024 entries, where code zero stands for a 64-entry table. A global control register holds the engine-enable bit. It also starts a hardware clear that walks the table one entry per clock and leaves every entry zero, which makes its type field free.

Top module: `fwd_table_store`

## Requirements
- R1: After reset every staging word, the enable bit and busy_o read 0, and every entry is all-zero (type bits 61:60 = 0, free).
- R2: Staging word offset 0x34 holds entry bits 67:64 in its bits 3:0, and its bits 31:4 read 0. Offset 0x38 holds bits 63:32 and offset 0x3C holds bits 31:0. Each staging word reads back the value last stored in it.
- R3: A write to offset 0x20 with bit 31 = 0 and index bits 15:0 below DEPTH copies that entry into the staging words by the next clock edge.
- R4: A write to offset 0x20 with bit 31 = 1 and an in-range index stores the staging words, as they stand at that write, into the entry.
- R5: A table-control write whose index is at or above DEPTH changes neither the staging words nor any entry.
- R6: Offset 0x04 reads the size code in bits 4:0 (0 for DEPTH below 1024, else DEPTH/1024) with all other bits 0. Offset 0x20 and unmapped offsets read 0.
- R7: Writing offset 0x08 with bit 30 = 1 while idle raises busy_o from the next edge for exactly DEPTH cycles. Afterwards every entry is all-zero.
- R8: Offset 0x08 reads the stored enable in bit 31 (also driven on enable_o) and reads busy in bit 30. So bit 30 reads 1 during the clear and returns to 0 by itself.
- R9: While busy_o is high, table-control writes are ignored, and staging-word writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| busy_o | output | 1 | Hardware clear in progress |
| enable_o | output | 1 | Stored engine-enable bit |

## Verification
Read data is combinational from the current offset. A value stored by a write at one edge is therefore visible in the cycle right after that edge: staging words, loaded entries and the enable bit. busy_o rises one edge after the clear write and stays high for DEPTH cycles. The bench's reference model applies each write at the same edge as the design and compares every output shortly after each falling edge, so each result is checked in the first cycle it is due. The clear length is also counted in falling edges and must equal DEPTH exactly.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int WORD_W  = 32;
  localparam int ENTRY_W = 68;
  localparam int TOP_W   = ENTRY_W - 2 * WORD_W;

  localparam logic [7:0] OFF_STATUS = 8'h04;
  localparam logic [7:0] OFF_GCTRL  = 8'h08;
  localparam logic [7:0] OFF_TCTRL  = 8'h20;
  localparam logic [7:0] OFF_WORD0  = 8'h34;
  localparam logic [7:0] OFF_WORD1  = 8'h38;
  localparam logic [7:0] OFF_WORD2  = 8'h3C;

  localparam int BIT_CMD_WR = 31;
  localparam int BIT_ENABLE = 31;
  localparam int BIT_CLEAR  = 30;

  typedef logic [ENTRY_W-1:0] entry_t;

  function automatic logic [4:0] size_code(int depth);
    return (depth < 1024) ? 5'd0 : 5'(depth / 1024);
  endfunction
endpackage

// File: rtl/fts_window.sv
module fts_window
  import fts_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              load_i,
  input  entry_t            load_entry_i,
  output entry_t            entry_o
);
  // word 0 is most significant
  for (genvar g = 0; g < 3; g++) begin : g_word
    localparam int LO = (2 - g) * WORD_W;
    localparam int HI = (g == 0) ? ENTRY_W - 1 : LO + WORD_W - 1;
    logic [HI-LO:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (load_i)  q <= load_entry_i[HI:LO];
      else if (wr_i[g]) q <= wdata_i[HI-LO:0];
    end
    assign entry_o[HI:LO] = q;
  end
endmodule

// File: rtl/fts_entry_mem.sv
module fts_entry_mem
  import fts_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  entry_t           wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output entry_t           rdata_o
);
  entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fts_clear_walk.sv
module fts_clear_walk #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
    end else if (busy_o) begin
      if (idx_o == LAST) busy_o <= 1'b0;
      else               idx_o  <= idx_o + 1'b1;
    end else if (start_i) begin
      busy_o <= 1'b1;
      idx_o  <= '0;
    end
  end
endmodule

// File: rtl/fwd_table_store.sv
module fwd_table_store
  import fts_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int IDX_FIELD_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        busy_o,
  output logic        enable_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [4:0] SIZE_CODE = size_code(DEPTH);

  logic [IDX_FIELD_W-1:0] cmd_idx;
  logic                   in_range, wr_tctrl, do_load, do_commit, clr_start;
  logic [2:0]             word_wr;
  logic [IDX_W-1:0]       walk_idx, mem_waddr;
  logic                   mem_we;
  entry_t                 staged, mem_rdata, mem_wdata;
  logic                   enable_q;

  assign cmd_idx   = reg_wdata_i[IDX_FIELD_W-1:0];
  assign in_range  = cmd_idx < IDX_FIELD_W'(DEPTH);
  assign wr_tctrl  = reg_we_i && (reg_addr_i == OFF_TCTRL) && !busy_o && in_range;
  assign do_load   = wr_tctrl && !reg_wdata_i[BIT_CMD_WR];
  assign do_commit = wr_tctrl &&  reg_wdata_i[BIT_CMD_WR];
  assign clr_start = reg_we_i && (reg_addr_i == OFF_GCTRL) && reg_wdata_i[BIT_CLEAR];

  assign word_wr[0] = reg_we_i && (reg_addr_i == OFF_WORD0);
  assign word_wr[1] = reg_we_i && (reg_addr_i == OFF_WORD1);
  assign word_wr[2] = reg_we_i && (reg_addr_i == OFF_WORD2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) enable_q <= 1'b0;
    else if (reg_we_i && reg_addr_i == OFF_GCTRL) enable_q <= reg_wdata_i[BIT_ENABLE];
  end
  assign enable_o = enable_q;

  fts_window u_window (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (word_wr),
    .wdata_i      (reg_wdata_i),
    .load_i       (do_load),
    .load_entry_i (mem_rdata),
    .entry_o      (staged)
  );

  fts_clear_walk #(.DEPTH(DEPTH)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (clr_start),
    .busy_o  (busy_o),
    .idx_o   (walk_idx)
  );

  // clear walk owns the write port while busy
  assign mem_we    = busy_o || do_commit;
  assign mem_waddr = busy_o ? walk_idx : cmd_idx[IDX_W-1:0];
  assign mem_wdata = busy_o ? '0 : staged;

  fts_entry_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (cmd_idx[IDX_W-1:0]),
    .rdata_o (mem_rdata)
  );

  always_comb begin
    unique case (reg_addr_i)
      OFF_STATUS: reg_rdata_o = {27'b0, SIZE_CODE};
      OFF_GCTRL:  reg_rdata_o = {enable_q, busy_o, 30'b0};
      OFF_WORD0:  reg_rdata_o = {{(WORD_W-TOP_W){1'b0}}, staged[ENTRY_W-1:2*WORD_W]};
      OFF_WORD1:  reg_rdata_o = staged[2*WORD_W-1:WORD_W];
      OFF_WORD2:  reg_rdata_o = staged[WORD_W-1:0];
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fts_checker.sv
module fts_checker
  import fts_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [7:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        busy_o,
  input entry_t      staged_i
);
  int run_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_cnt <= 0;
    else if (!busy_o) run_cnt <= 0;
    else              run_cnt <= run_cnt + 1;
  end

  p_clear_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == OFF_GCTRL && reg_wdata_i[BIT_CLEAR] && !busy_o |=> busy_o);

  p_busy_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && run_cnt == DEPTH - 1 |=> !busy_o);

  p_busy_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && run_cnt < DEPTH - 1 |=> busy_o);

  p_clr_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && reg_addr_i == OFF_GCTRL |-> reg_rdata_o[BIT_CLEAR]);

  p_oob_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == OFF_TCTRL && reg_wdata_i[15:0] >= 16'(DEPTH) |=> $stable(staged_i));

  p_ctrl_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == OFF_TCTRL && busy_o |=> $stable(staged_i));
endmodule

bind fwd_table_store fts_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .busy_o      (busy_o),
  .staged_i    (staged)
);

// File: tb/fwd_table_store_bench.sv
module fwd_table_store_bench;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy, enable;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  fwd_table_store u_fwd_table_store (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .busy_o(busy), .enable_o(enable)
  );

  // reference model
  logic [67:0] m_mem [DEPTH];
  logic [67:0] m_stage;
  bit          m_busy, m_en;
  int          m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
      m_stage = '0; m_busy = 0; m_en = 0; m_cnt = 0;
    end else begin
      automatic bit was_busy = m_busy;
      automatic int idx = int'(wdata[15:0]);
      if (m_busy) begin
        m_mem[m_cnt] = '0;
        if (m_cnt == DEPTH - 1) m_busy = 0; else m_cnt++;
      end
      if (we) begin
        case (addr)
          8'h08: begin
            m_en = wdata[31];
            if (wdata[30] && !was_busy) begin m_busy = 1; m_cnt = 0; end
          end
          8'h20: if (!was_busy && idx < DEPTH) begin
            if (wdata[31]) m_mem[idx] = m_stage;
            else           m_stage = m_mem[idx];
          end
          8'h34: m_stage[67:64] = wdata[3:0];
          8'h38: m_stage[63:32] = wdata;
          8'h3C: m_stage[31:0]  = wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h04: return 32'h0;
      8'h08: return {m_en, m_busy, 30'b0};
      8'h34: return {28'b0, m_stage[67:64]};
      8'h38: return m_stage[63:32];
      8'h3C: return m_stage[31:0];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R7 busy", 32'(busy), 32'(m_busy));
      check("R8 enable", 32'(enable), 32'(m_en));
      check((addr == 8'h04) ? "R6 cyc" : (addr == 8'h08) ? "R8 cyc" : "R2 cyc",
            rdata, m_read(addr));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic rd_entry(string req, int idx, logic [67:0] exp);
    wr(8'h20, 32'(idx));
    rd(req, 8'h34, {28'b0, exp[67:64]});
    rd(req, 8'h38, exp[63:32]);
    rd(req, 8'h3C, exp[31:0]);
  endtask

  task automatic stage(logic [67:0] e);
    wr(8'h34, {28'hFFFFFFF, e[67:64]});
    wr(8'h38, e[63:32]);
    wr(8'h3C, e[31:0]);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  localparam logic [67:0] E_A = 68'hA_1234_5678_9ABC_DEF0;
  localparam logic [67:0] E_B = 68'h5_2000_0000_0000_0001;
  localparam logic [67:0] E_C = 68'h3_3000_0000_C0DE_0063;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1", 8'h08, 32'h0);
    rd("R1", 8'h34, 32'h0);
    rd("R1", 8'h3C, 32'h0);
    check("R1 busy", 32'(busy), 32'h0);
    // R6 status and unmapped reads
    rd("R6", 8'h04, 32'h0);
    rd("R6", 8'h20, 32'h0);
    rd("R6", 8'h10, 32'h0);
    // R2 word layout
    stage(E_A);
    rd("R2", 8'h34, 32'h0000_000A);
    rd("R2", 8'h38, 32'h1234_5678);
    rd("R2", 8'h3C, 32'h9ABC_DEF0);
    // R4 commit, R3 load
    wr(8'h20, 32'h8000_0005);
    stage(E_B);
    wr(8'h20, 32'h8000_003F);
    rd_entry("R3", 5, E_A);
    rd_entry("R1", 0, 68'h0);
    rd_entry("R3", 63, E_B);
    // R5 out-of-range index
    stage(E_C);
    wr(8'h20, 32'h8000_0040);
    rd("R5", 8'h3C, E_C[31:0]);
    wr(8'h20, 32'h0000_0045);
    rd("R5", 8'h38, E_C[63:32]);
    rd_entry("R5", 0, 68'h0);
    rd_entry("R5", 63, E_B);
    // R7/R8/R9 clear with activity
    wr(8'h08, 32'hC000_0000);
    rd("R8", 8'h08, 32'hC000_0000);
    check("R7 busy", 32'(busy), 32'h1);
    wr(8'h20, 32'h0000_0005);
    rd("R9", 8'h38, E_B[63:32]);
    wr(8'h3C, 32'h0BAD_CAFE);
    rd("R9", 8'h3C, 32'h0BAD_CAFE);
    wr(8'h20, 32'h8000_0007);
    while (busy) @(negedge clk);
    rd("R8", 8'h08, 32'h8000_0000);
    rd_entry("R7", 5, 68'h0);
    rd_entry("R7", 63, 68'h0);
    rd_entry("R9", 7, 68'h0);
    // R7 exact length
    stage(E_C);
    wr(8'h20, 32'h8000_0021);
    wr(8'h08, 32'h4000_0000);
    begin
      int n = 0;
      while (busy) begin @(negedge clk); n++; end
      check("R7 length", 32'(n), 32'(DEPTH));
    end
    rd("R8", 8'h08, 32'h0);
    rd_entry("R7", 33, 68'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule